// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Unit

This block decides where a small processor fetches its reset vector and where its interrupt jump table sits in program memory. A static boot configuration input picks the reset address. A vector-select bit in a small control register picks the table base: either the bottom of program memory or the start of the boot section. The boot-section start comes in on a static input. All addresses are 14-bit word addresses. Given an interrupt number, the block returns the jump address for that interrupt.

The vector-select bit is guarded. Software must first set a change-enable bit. That bit opens a four-cycle window, and the new vector-select value must be written inside it. While this sequence runs, the block raises a global interrupt-block output. The output does not modify the processor's interrupt-enable flag. After a vector-select write, the block output stays high until the processor reports, on its instruction-completed strobe, that one further instruction has finished.

The control register has eight bits:
- Bits 7..5 are three external-interrupt enables that software can read and write freely.
- Bit 1 is vector-select.
- Bit 0 is change-enable.
- Bits 4..2 always read as zero.

Top module: `vector_relocator`

## Requirements
- R1: After reset, the register reads 0x00, `irq_block` is low, vector-select is clear and `ext_irq_en` is 0.
- R2: On every register write, bits 7..5 are loaded into `ext_irq_en` and read back in `reg_rdata[7:5]`. Bits 4..2 of `reg_rdata` are always 0.
- R3: A write with bit 0 set opens the change window. After that write edge, `reg_rdata[0]` reads 1.
- R4: A write with bit 0 clear, made while the window is open, loads bit 1 into vector-select (`reg_rdata[1]`) and closes the window at the same edge. The window is open during the four clock cycles that follow the opening write.
- R5: A write with bit 0 clear made while the window is closed leaves vector-select unchanged.
- R6: If vector-select is not written, change-enable reads 1 for exactly four cycles and then clears by itself.
- R7: A write with bit 0 set never changes vector-select, even when bit 1 is also set. If the window is already open, such a write restarts the four-cycle count.
- R8: `irq_block` is high in every cycle in which change-enable reads 1.
- R9: After an accepted vector-select write, `irq_block` stays high until the clock edge that samples the first `insn_done` pulse after the write cycle, and it goes low after that edge. An `insn_done` pulse in the write cycle itself does not count.
- R10: `reset_addr` is 0x0000 when `reset_at_zero` is 1, and equals `boot_base` when `reset_at_zero` is 0.
- R11: For `irq_num` n in the range 1..21, `vec_addr` = base + 2·(n−1). The base is 0x0000 when vector-select is clear and `boot_base` when it is set. With vector-select clear, vector 2 is at 0x0002 and vector 21 is at 0x0028.
- R12: For `irq_num` 0 or any value above 21, `vec_addr` equals the table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| insn_done | input | 1 | Instruction-completed strobe from the processor |
| reset_at_zero | input | 1 | Boot configuration: 1 = reset address 0, 0 = boot start |
| boot_base | input | 14 | Boot-section start word address |
| irq_num | input | 5 | Vector number to look up |
| vec_addr | output | 14 | Jump address of vector `irq_num` |
| reset_addr | output | 14 | Reset fetch address |
| irq_block | output | 1 | Interrupts are masked while high |
| ext_irq_en | output | 3 | External interrupt enables (register bits 7..5) |

## Verification
The bench writes vector-select at every position of the window:
- In the first cycle and in the fourth cycle, where the write must be accepted.
- In the fifth cycle, where the write must be dropped. A counter off by one would either move the table too late or lock it out too early.

It re-arms an open window and then writes after the original window would have expired. A design without the restart would reject that write.

It writes both guarded bits at once. A design that treated this as a select write would move the table without an unlock.

It holds `insn_done` low for several cycles after a select write, and it pulses `insn_done` in the write cycle itself. A design that released the block early, or that counted the write instruction as the following instruction, would unmask interrupts too soon. Random traffic then checks address lookups against out-of-range vector numbers and both reset configurations.

// File: rtl/vr_pkg.sv
package vr_pkg;
  // Control register field positions; software depends on them.
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned EN_HI   = 7;
  localparam int unsigned EN_LO   = 5;
  localparam int unsigned SEL_BIT = 1;
  localparam int unsigned CE_BIT  = 0;
  localparam int unsigned EN_W    = EN_HI - EN_LO + 1;

  typedef struct packed {
    logic [EN_W-1:0] en;
    logic            sel;
    logic            ce;
  } ctrl_t;
endpackage

// File: rtl/vr_unlock.sv
module vr_unlock #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_ce,
  input  logic wr_sel,
  input  logic insn_done,
  output logic ce,
  output logic sel,
  output logic block
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WINDOW);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          hold_q, hold_d;
  logic          ce_q;
  logic          arm_wr, sel_wr;

  assign ce_q   = (cnt_q != '0);
  assign arm_wr = wr_en && wr_ce;
  assign sel_wr = wr_en && !wr_ce && ce_q;

  always_comb begin
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    hold_d = hold_q && !insn_done;
    if (arm_wr) begin
      cnt_d = WIN_LOAD;
    end else if (sel_wr) begin
      cnt_d  = '0;
      sel_d  = wr_sel;
      hold_d = 1'b1;
    end else if (ce_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      hold_q <= hold_d;
    end
  end

  assign ce    = ce_q;
  assign sel   = sel_q;
  assign block = ce_q || hold_q;

  // R4 R5 R7
  sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wr_en && !wr_ce && ce_q));

  // R3
  ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_q) |-> $past(wr_en && wr_ce));

  // R6
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_LOAD);

  // R4
  ce_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ce && ce_q) |=> !ce_q);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !insn_done && !(wr_en && wr_ce)) |=> block);
endmodule

// File: rtl/vr_addr_map.sv
module vr_addr_map #(
  parameter int unsigned AW    = 14,
  parameter int unsigned NVEC  = 21,
  parameter int unsigned NUM_W = 5
) (
  input  logic [AW-1:0]    boot_base,
  input  logic             reset_at_zero,
  input  logic             sel,
  input  logic [NUM_W-1:0] irq_num,
  output logic [AW-1:0]    reset_addr,
  output logic [AW-1:0]    vec_addr
);
  localparam int unsigned STRIDE_SH = 1;

  logic [AW-1:0] tbl_base;
  logic [AW-1:0] slot;
  logic          in_range;

  assign reset_addr = reset_at_zero ? '0 : boot_base;
  assign tbl_base   = sel ? boot_base : '0;
  assign in_range   = (irq_num != '0) && (irq_num <= NUM_W'(NVEC));

  always_comb begin
    slot = '0;
    if (in_range) begin
      slot = (AW'(irq_num) - AW'(1)) << STRIDE_SH;
    end
  end

  assign vec_addr = tbl_base + slot;
endmodule

// File: rtl/vector_relocator.sv
module vector_relocator
  import vr_pkg::*;
#(
  parameter int unsigned AW     = 14,
  parameter int unsigned NVEC   = 21,
  parameter int unsigned WINDOW = 4,
  parameter int unsigned NUM_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              insn_done,
  input  logic              reset_at_zero,
  input  logic [AW-1:0]     boot_base,
  input  logic [NUM_W-1:0]  irq_num,
  output logic [AW-1:0]     vec_addr,
  output logic [AW-1:0]     reset_addr,
  output logic              irq_block,
  output logic [EN_W-1:0]   ext_irq_en
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [EN_W-1:0] en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (reg_wr) en_d = reg_wdata[EN_HI:EN_LO];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) en_q <= '0;
    else          en_q <= en_d;
  end

  ctrl_t ctrl;
  logic  ce_w, sel_w, block_w;

  vr_unlock #(.WINDOW(WINDOW)) u_unlock (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (reg_wr),
    .wr_ce     (reg_wdata[CE_BIT]),
    .wr_sel    (reg_wdata[SEL_BIT]),
    .insn_done (insn_done),
    .ce        (ce_w),
    .sel       (sel_w),
    .block     (block_w)
  );

  vr_addr_map #(.AW(AW), .NVEC(NVEC), .NUM_W(NUM_W)) u_map (
    .boot_base     (boot_base),
    .reset_at_zero (reset_at_zero),
    .sel           (sel_w),
    .irq_num       (irq_num),
    .reset_addr    (reset_addr),
    .vec_addr      (vec_addr)
  );

  assign ctrl.en  = en_q;
  assign ctrl.sel = sel_w;
  assign ctrl.ce  = ce_w;

  always_comb begin
    reg_rdata                 = '0;
    reg_rdata[EN_HI:EN_LO]    = ctrl.en;
    reg_rdata[SEL_BIT]        = ctrl.sel;
    reg_rdata[CE_BIT]         = ctrl.ce;
  end

  assign irq_block  = block_w;
  assign ext_irq_en = en_q;

  // R8
  block_on_arm_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (reg_wr && reg_wdata[CE_BIT]) |=> irq_block);

  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_wr |=> (ext_irq_en == $past(reg_wdata[EN_HI:EN_LO])));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    reg_rdata[EN_LO-1:SEL_BIT+1] == '0);
endmodule

// File: tb/test_vector_relocator.sv
module test_vector_relocator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        insn_done = 1'b0;
  logic        reset_at_zero = 1'b1;
  logic [13:0] boot_base = 14'h3800;
  logic [4:0]  irq_num = '0;
  logic [13:0] vec_addr;
  logic [13:0] reset_addr;
  logic        irq_block;
  logic [2:0]  ext_irq_en;

  always #10 clk = ~clk;

  vector_relocator i_vector_relocator (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .insn_done(insn_done), .reset_at_zero(reset_at_zero),
    .boot_base(boot_base), .irq_num(irq_num), .vec_addr(vec_addr),
    .reset_addr(reset_addr), .irq_block(irq_block), .ext_irq_en(ext_irq_en)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  int       m_cnt = 0;
  bit       m_sel = 0;
  bit       m_hold = 0;
  bit [2:0] m_en = '0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_vec(bit sel, logic [13:0] base, logic [4:0] n);
    logic [13:0] b;
    b = sel ? base : 14'h0;
    if (n >= 1 && n <= 21) return b + 14'(2 * (int'(n) - 1));
    return b;
  endfunction

  function automatic logic [7:0] exp_reg();
    return {m_en, 3'b000, m_sel, (m_cnt != 0)};
  endfunction

  task automatic compare_all();
    chk("R2/R3/R4 reg_rdata", 16'(reg_rdata), 16'(exp_reg()));
    chk("R8/R9 irq_block", 16'(irq_block), 16'(m_cnt != 0 || m_hold));
    chk("R10 reset_addr", 16'(reset_addr), 16'(reset_at_zero ? 14'h0 : boot_base));
    chk("R11/R12 vec_addr", 16'(vec_addr), 16'(exp_vec(m_sel, boot_base, irq_num)));
    chk("R2 ext_irq_en", 16'(ext_irq_en), 16'(m_en));
  endtask

  task automatic model_edge();
    bit arm, selw;
    arm  = reg_wr && reg_wdata[0];
    selw = reg_wr && !reg_wdata[0] && (m_cnt != 0);
    if (reg_wr) m_en = reg_wdata[7:5];
    m_hold = m_hold && !insn_done;
    if (arm) m_cnt = 4;
    else if (selw) begin m_cnt = 0; m_sel = reg_wdata[1]; m_hold = 1; end
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
  endtask

  task automatic cyc(bit wr, logic [7:0] d, bit done, logic [4:0] n);
    @(negedge clk);
    compare_all();
    reg_wr = wr; reg_wdata = d; insn_done = done; irq_num = n;
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reg_rdata", 16'(reg_rdata), 16'h0);
    chk("R1 irq_block", 16'(irq_block), 16'h0);
    cyc(0, 8'h00, 0, 5'd21);
    chk("R11 vec 21 base low", 16'(vec_addr), 16'h0028);
    // R2 enables, reserved bits ignored
    cyc(1, 8'hE0, 0, 5'd2);
    cyc(1, 8'h1C, 0, 5'd2);
    cyc(0, 8'h00, 0, 5'd2);
    chk("R2 reserved bits read zero", 16'(reg_rdata), 16'h0000);
    chk("R11 vec 2 base low", 16'(vec_addr), 16'h0002);
    // R4 select written in first window cycle
    cyc(1, 8'h01, 1, 5'd2);
    cyc(1, 8'h02, 1, 5'd21);
    cyc(0, 8'h00, 1, 5'd21);
    chk("R11 vec 21 relocated", 16'(vec_addr), 16'h3828);
    cyc(0, 8'h00, 0, 5'd2);
    chk("R11 vec 2 relocated", 16'(vec_addr), 16'h3802);
    // R4 select written in fourth window cycle
    cyc(1, 8'h01, 0, 5'd3);
    cyc(0, 8'h00, 0, 5'd3);
    cyc(0, 8'h00, 0, 5'd3);
    cyc(0, 8'h00, 0, 5'd3);
    cyc(1, 8'h00, 0, 5'd3);
    cyc(0, 8'h00, 1, 5'd3);
    chk("R4 fourth-cycle write accepted", 16'(reg_rdata[1]), 16'h0);
    // R5/R6 fifth cycle is too late
    cyc(1, 8'h01, 0, 5'd4);
    repeat (4) cyc(0, 8'h00, 0, 5'd4);
    cyc(1, 8'h02, 0, 5'd4);
    cyc(0, 8'h00, 0, 5'd4);
    chk("R5 late write dropped", 16'(reg_rdata[1]), 16'h0);
    chk("R6 window closed", 16'(irq_block), 16'h0);
    // R7 both bits set, then restart
    cyc(1, 8'h03, 0, 5'd5);
    cyc(0, 8'h00, 0, 5'd5);
    chk("R7 both bits no select", 16'(reg_rdata[1]), 16'h0);
    cyc(0, 8'h00, 0, 5'd5);
    cyc(1, 8'h01, 0, 5'd5);
    repeat (3) cyc(0, 8'h00, 0, 5'd5);
    cyc(1, 8'h02, 0, 5'd5);
    // R9 hold until a later insn_done; done during the write itself ignored
    cyc(0, 8'h00, 0, 5'd5);
    chk("R7 restart accepted", 16'(reg_rdata[1]), 16'h1);
    cyc(0, 8'h00, 0, 5'd5);
    chk("R9 hold persists", 16'(irq_block), 16'h1);
    cyc(1, 8'h01, 0, 5'd0);
    cyc(1, 8'h00, 1, 5'd0);
    cyc(0, 8'h00, 0, 5'd0);
    chk("R9 write-cycle done ignored", 16'(irq_block), 16'h1);
    cyc(0, 8'h00, 1, 5'd0);
    cyc(0, 8'h00, 0, 5'd30);
    chk("R9 released after done", 16'(irq_block), 16'h0);
    chk("R12 out of range", 16'(vec_addr), 16'h0000);
    // R10 boot reset config
    reset_at_zero = 1'b0;
    cyc(0, 8'h00, 0, 5'd1);
    chk("R10 reset at boot", 16'(reset_addr), 16'h3800);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit wr;
      logic [7:0] d;
      wr = ($urandom % 3) == 0;
      d  = 8'($urandom);
      if (($urandom % 2) == 0) d[0] = 1'b0;
      if (($urandom % 64) == 0) reset_at_zero = ~reset_at_zero;
      if (i == 2000) boot_base = 14'h3C00;
      cyc(wr, d, ($urandom % 3) == 0, 5'($urandom));
    end
    @(negedge clk);
    compare_all();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule